// File: doc/BRIEF.md
# Speaker and Timer Gate Control Port

This block is the byte-wide I/O register that sits at the legacy system-control
port `0x61`. Software writes it to open or close the gate of the third
interval-timer channel and to allow that channel's square wave through to the
speaker. Software reads it to see both control bits, the live level of the timer
channel output and a flag that flips every time the register is read. Polling
code uses that flag as a crude time base.

The register answers only byte-sized accesses whose address matches the port
parameter. Accesses of any other size or to any other address leave its state
alone, and reads of that kind return zero on the data bus. The gate output goes
to the external timer. The speaker drive output is the timer output qualified by
the enable bit. The timer counter itself lies outside this block.

Top module: `spkr_gate_port`

## Requirements
- R1: After reset the gate output is 0, the speaker enable is 0 and the read flag is 0. A first valid read therefore returns only the timer level in bit 5.
- R2: A write with `io_wr`=1, `io_addr`=PORT_ADDR (default 0x0061) and `io_size`=0 (byte) loads `io_wdata` bit 0 into the gate. The gate appears on `gate_out` from the next cycle.
- R3: The same valid byte write loads `io_wdata` bit 1 into the speaker enable. From the next cycle the enable is visible in read bit 1 and on `spk_out`.
- R4: A write to any other address, or with `io_size` other than 0, changes neither the gate, the enable nor the flag.
- R5: During a valid byte read (`io_rd`=1, matching address, `io_size`=0), `io_rdata` carries the gate in bit 0, the enable in bit 1, the flag in bit 4 and the live `tmr_out` in bit 5. Bits 2, 3, 6 and 7 are 0. In every other cycle `io_rdata` is 0.
- R6: Each valid byte read inverts the flag after the read. The read itself returns the value from before the inversion. Reads with the wrong address or size leave the flag unchanged.
- R7: `spk_out` is high exactly when `tmr_out` is high and the speaker enable is set.
- R8: When a valid read and a valid write fall in the same cycle, the read returns the values from before the write. The write still takes effect and the flag still inverts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Access size code, 0 = byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid during the read cycle |
| tmr_out | input | 1 | Live output of timer channel 2 |
| gate_out | output | 1 | Gate to timer channel 2 |
| spk_out | output | 1 | Speaker drive |

## Verification
A read and a write to the port can land in the same cycle. The flag inversion and
the control-bit update then take effect at the same edge, while the returned byte
must still show the state from before that edge. The bench provokes this with
directed cycles that raise both strobes at once. It also provokes it in a long
random phase where both strobes, the address and the size vary independently. A
behavioural model predicts the returned byte from its pre-edge state and then
applies the write and the flag flip. The bench compares the model against the
data bus, the gate and the speaker output on every clock.

// File: rtl/spg_pkg.sv
package spg_pkg;
   localparam int GATE_BIT = 0;
   localparam int EN_BIT   = 1;
   localparam int TOG_BIT  = 4;
   localparam int TMR_BIT  = 5;
   localparam int MIN_DATA_W = TMR_BIT + 1;

   typedef struct packed {
      logic tog;
      logic en;
      logic gate;
   } spg_state_t;
endpackage

// File: rtl/spg_decode.sv
module spg_decode #(
   parameter int ADDR_W    = 16,
   parameter int SIZE_W    = 2,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h61,
   parameter logic [SIZE_W-1:0] BYTE_CODE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   input  logic              wr,
   input  logic              rd,
   output logic              wr_hit,
   output logic              rd_hit
);
   logic sel;

   initial begin
      if (ADDR_W < 1 || SIZE_W < 1)
         $error("spg_decode: address and size widths must be positive");
   end

   assign sel    = (addr == PORT_ADDR) && (size == BYTE_CODE);
   assign wr_hit = wr && sel;
   assign rd_hit = rd && sel;
endmodule

// File: rtl/spg_ctrl_reg.sv
module spg_ctrl_reg
   import spg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] wdata,
   output spg_state_t        st
);
   spg_state_t st_q;
   logic unused_wdata;

   initial begin
      if (DATA_W < MIN_DATA_W)
         $error("spg_ctrl_reg: DATA_W too small for the bit layout");
   end

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         if (wr_hit) begin
            st_q.gate <= wdata[GATE_BIT];
            st_q.en   <= wdata[EN_BIT];
         end
         if (rd_hit)
            st_q.tog <= ~st_q.tog;
      end
   end

   assign st = st_q;

   a_r6_flag_flips : assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (st_q.tog != $past(st_q.tog)));
   a_r6_flag_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(st_q.tog));
   a_r4_ctrl_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> ($stable(st_q.gate) && $stable(st_q.en)));
endmodule

// File: rtl/spg_read_mux.sv
module spg_read_mux
   import spg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              rd_hit,
   input  spg_state_t        st,
   input  logic              tmr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] image;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == GATE_BIT) begin : g_gate
         assign image[i] = st.gate;
      end else if (i == EN_BIT) begin : g_en
         assign image[i] = st.en;
      end else if (i == TOG_BIT) begin : g_tog
         assign image[i] = st.tog;
      end else if (i == TMR_BIT) begin : g_tmr
         assign image[i] = tmr;
      end else begin : g_zero
         assign image[i] = 1'b0;
      end
   end

   assign rdata = rd_hit ? image : '0;

   always_comb begin
      a_r5_idle_zero : assert (rd_hit || rdata == '0);
   end
endmodule

// File: rtl/spkr_gate_port.sv
module spkr_gate_port
   import spg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SIZE_W = 2,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h61,
   parameter logic [SIZE_W-1:0] BYTE_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [SIZE_W-1:0] io_size,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              tmr_out,
   output logic              gate_out,
   output logic              spk_out
);
   localparam logic [DATA_W-1:0] ZERO_MASK =
      ~(DATA_W'(1) << GATE_BIT | DATA_W'(1) << EN_BIT |
        DATA_W'(1) << TOG_BIT  | DATA_W'(1) << TMR_BIT);

   logic       wr_hit, rd_hit;
   spg_state_t st;

   initial begin
      if (DATA_W < MIN_DATA_W)
         $error("spkr_gate_port: DATA_W must hold bit %0d", TMR_BIT);
   end

   spg_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
                .PORT_ADDR(PORT_ADDR), .BYTE_CODE(BYTE_CODE)) i_dec (
      .addr(io_addr), .size(io_size), .wr(io_wr), .rd(io_rd),
      .wr_hit(wr_hit), .rd_hit(rd_hit));

   spg_ctrl_reg #(.DATA_W(DATA_W)) i_reg (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit),
      .wdata(io_wdata), .st(st));

   spg_read_mux #(.DATA_W(DATA_W)) i_mux (
      .rd_hit(rd_hit), .st(st), .tmr(tmr_out), .rdata(io_rdata));

   assign gate_out = st.gate;
   assign spk_out  = tmr_out & st.en;

   a_r2_gate_loads : assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_ADDR && io_size == BYTE_CODE)
      |=> (gate_out == $past(io_wdata[GATE_BIT])));
   a_r4_gate_ignores : assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && (io_addr != PORT_ADDR || io_size != BYTE_CODE))
      |=> $stable(gate_out));
   a_r5_zero_bits : assert property (@(posedge clk) disable iff (!rst_n)
      (io_rdata & ZERO_MASK) == '0);
   a_r7_spk_needs_tmr : assert property (@(posedge clk) disable iff (!rst_n)
      spk_out |-> tmr_out);
endmodule

// File: tb/test_spkr_gate_port.sv
module test_spkr_gate_port;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] io_addr = 0;
   logic [1:0]  io_size = 0;
   logic        io_wr = 0, io_rd = 0;
   logic [7:0]  io_wdata = 0;
   logic [7:0]  io_rdata;
   logic        tmr_out = 0;
   logic        gate_out, spk_out;

   int checks = 0, fails = 0;
   bit m_gate = 0, m_en = 0, m_tog = 0;

   always #4 clk = ~clk;

   spkr_gate_port i_spkr_gate_port (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .tmr_out(tmr_out), .gate_out(gate_out), .spk_out(spk_out));

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one bus cycle: drive at negedge, compare, then advance model at posedge
   task automatic step(string tag, bit wr, bit rd, logic [15:0] a,
                       logic [1:0] sz, logic [7:0] wd, bit tmr);
      bit hit;
      logic [7:0] exp_rd;
      @(negedge clk);
      io_wr = wr; io_rd = rd; io_addr = a; io_size = sz;
      io_wdata = wd; tmr_out = tmr;
      #1;
      hit = (a == 16'h0061) && (sz == 2'd0);
      exp_rd = (rd && hit) ? {2'b00, tmr, m_tog, 2'b00, m_en, m_gate} : 8'h00;
      chk(tag, "rdata", io_rdata, exp_rd);
      chk(tag, "gate_out", {7'b0, gate_out}, {7'b0, m_gate});
      chk(tag, "spk_out", {7'b0, spk_out}, {7'b0, tmr & m_en});
      @(posedge clk);
      if (wr && hit) begin m_gate = wd[0]; m_en = wd[1]; end
      if (rd && hit) m_tog = ~m_tog;
   endtask

   initial begin : watchdog
      #400000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1: reset state visible through a read with timer high
      step("R1", 0, 1, 16'h0061, 0, 8'h00, 1);
      step("R1", 0, 0, 16'h0061, 0, 8'h00, 0);
      // R2 R3: write gate and enable
      step("R2", 1, 0, 16'h0061, 0, 8'h01, 0);
      step("R2", 0, 1, 16'h0061, 0, 8'h00, 1);
      step("R3", 1, 0, 16'h0061, 0, 8'hFE, 1);
      step("R3", 0, 1, 16'h0061, 0, 8'h00, 1);
      step("R7", 0, 0, 16'h0000, 0, 8'h00, 0);
      step("R7", 0, 0, 16'h0000, 0, 8'h00, 1);
      // R4: wrong address and wrong size writes ignored
      step("R4", 1, 0, 16'h0060, 0, 8'h01, 1);
      step("R4", 1, 0, 16'h0061, 1, 8'h01, 1);
      step("R4", 1, 0, 16'h0161, 0, 8'h01, 1);
      step("R4", 0, 1, 16'h0061, 0, 8'h00, 1);
      // R6: non-matching reads do not flip, rdata zero (R5)
      step("R6", 0, 1, 16'h0062, 0, 8'h00, 1);
      step("R5", 0, 1, 16'h0061, 2, 8'h00, 1);
      step("R6", 0, 1, 16'h0061, 0, 8'h00, 0);
      step("R6", 0, 1, 16'h0061, 0, 8'h00, 0);
      // R8: read and write in the same cycle
      step("R8", 1, 1, 16'h0061, 0, 8'h03, 1);
      step("R8", 0, 1, 16'h0061, 0, 8'h00, 1);
      step("R8", 1, 1, 16'h0061, 0, 8'h00, 1);
      step("R8", 0, 1, 16'h0061, 0, 8'h00, 1);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         int r;
         r = $urandom_range(0, 3);
         a = (r == 0) ? 16'h0060 : (r == 1) ? 16'h0062 : 16'h0061;
         step("R8", 1'($urandom), 1'($urandom), a,
              2'($urandom_range(0, 3) == 0 ? 1 : 0), 8'($urandom),
              1'($urandom));
      end
      // R1: reset mid-run clears state
      @(negedge clk) rst_n = 0;
      @(negedge clk) rst_n = 1;
      m_gate = 0; m_en = 0; m_tog = 0;
      step("R1", 0, 1, 16'h0061, 0, 8'h00, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule